// File: doc/BRIEF.md
# Cascaded Priority Keypad Encoder

This block turns the key lines of a small calculator front panel into binary codes. A ten-key digit pad and a four-key operation pad each drive active-low lines, where a line pulled to 0 means the key is held. For each pad the block reports the code of the pressed key and a flag that says whether any key on that pad is down. The block has no clock and no storage. Its outputs follow the key lines directly.

The digit encoder is not written as one flat priority expression. It is a chain of identical four-input priority cells. The cell holding the highest keys is always enabled. Each cell passes an enable down to the next lower cell only while none of its own keys is pressed. A disabled cell drives a zero code and a low group select. Because of this, the cell outputs can be ORed together. The group select of the one active cell provides the upper code bits.

The digit pad's "any key" flag is the inverse of the enable leaving the lowest cell. The operation pad uses a single cell of the same design, which is permanently enabled. Debouncing, matrix scanning and latching the digit belong to the surrounding logic.

Top module: `kpe_keypad_encoder`

## Requirements
- R1: With exactly one digit line low, `digit_code_o` equals that line's index (0 to 9) as an unsigned binary number and `digit_valid_o` is 1.
- R2: With several digit lines low, `digit_code_o` equals the largest index among them. A lower-group key never changes the code while a key in a higher group is held.
- R3: `digit_valid_o` is 1 exactly when at least one bit of `digit_keys_n` is 0.
- R4: With all digit lines high, `digit_code_o` is 0000 and `digit_valid_o` is 0. A code of 0000 therefore means digit 0 only while the flag is high.
- R5: The operation lines encode as follows: bit 0 is add (code 00), bit 1 is subtract (01), bit 2 is multiply (10) and bit 3 is return (11). When several are low, the highest bit position wins.
- R6: `op_valid_o` is 1 exactly when at least one operation line is 0. With none low, `op_code_o` is 00.
- R7: The two pads are independent. Operation lines have no effect on the digit outputs, and digit lines have no effect on the operation outputs.
- R8: Inside the chain, at most one cell reports a pressed key. A cell whose enable is low outputs a zero code and a low group select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| digit_keys_n | input | NUM_KEYS (10) | Digit key lines, active low, bit i is digit i |
| op_keys_n | input | 4 | Operation key lines, active low: add, subtract, multiply, return at bits 0..3 |
| digit_code_o | output | $clog2(NUM_KEYS) (4) | Binary value of the highest pressed digit, 0 when idle |
| digit_valid_o | output | 1 | High while any digit key is pressed |
| op_code_o | output | 2 | Code of the highest pressed operation key, 0 when idle |
| op_valid_o | output | 1 | High while any operation key is pressed |

## Verification
The bench builds the block with the default of ten digit keys. With that setting the chain has three cells, and the top cell has only two real keys; its two unused lanes are held released. The stimulus therefore reaches every lane boundary: one key within a cell, keys spread across two or three cells, and presses confined to the partly filled top cell. Random patterns on both pads at once exercise the independence of the two pads. Directed cases cover all keys released and all keys pressed.

// File: rtl/kpe_pkg.sv
package kpe_pkg;

    // Lanes handled by one priority cell and the width of its local code.
    localparam int KPE_LANES  = 4;
    localparam int KPE_LANE_W = 2;

    // Operation codes; the value equals the bit position of the key line.
    typedef enum logic [KPE_LANE_W-1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_MUL = 2'd2,
        OP_RET = 2'd3
    } kpe_op_e;

    // Result leaving one priority cell.
    typedef struct packed {
        logic [KPE_LANE_W-1:0] code;   // index of highest held lane
        logic                  gs;     // some lane held while enabled
        logic                  eo;     // enable passed to lower cell
    } kpe_cell_t;

    // Number of cells needed to cover a given number of keys.
    function automatic int kpe_cells(input int keys);
        return (keys + KPE_LANES - 1) / KPE_LANES;
    endfunction

endpackage

// File: rtl/kpe_prio_cell.sv
module kpe_prio_cell
    import kpe_pkg::*;
(
    input  logic                 en_i,
    input  logic [KPE_LANES-1:0] lines_n_i,
    output kpe_cell_t            res_o
);

    logic [KPE_LANES-1:0] held;

    assign held = ~lines_n_i;

    always_comb begin
        res_o.code = '0;
        // Ascending scan: the last match, the highest lane, wins.
        for (int k = 0; k < KPE_LANES; k++) begin
            if (en_i && held[k]) begin
                res_o.code = KPE_LANE_W'(k);
            end
        end
        res_o.gs = en_i & (|held);
        res_o.eo = en_i & ~(|held);
    end

    // R8: a disabled cell stays quiet and passes no enable.
    always_comb begin
        if (!en_i) begin
            a_r8_disabled_quiet: assert (res_o.code == '0 && !res_o.gs && !res_o.eo)
                else $error("disabled cell not quiet");
        end
    end

endmodule

// File: rtl/kpe_cascade.sv
module kpe_cascade
    import kpe_pkg::*;
#(
    parameter int NUM_KEYS = 10,
    localparam int CODE_W  = $clog2(NUM_KEYS),
    localparam int NCELLS  = kpe_cells(NUM_KEYS),
    localparam int SPAN    = NCELLS * KPE_LANES,
    localparam int PAD     = SPAN - NUM_KEYS,
    localparam int SEL_W   = CODE_W - KPE_LANE_W
)(
    input  logic [NUM_KEYS-1:0] keys_n_i,
    output logic [CODE_W-1:0]   code_o,
    output logic                any_o
);

    logic [SPAN-1:0]   lines_n;
    logic [NCELLS:0]   en_chain;
    logic [NCELLS-1:0] gs_vec;
    kpe_cell_t         cell_res [NCELLS];

    // Unused lanes of the top cell read as released keys.
    generate
        if (PAD > 0) begin : g_pad
            assign lines_n = {{PAD{1'b1}}, keys_n_i};
        end else begin : g_nopad
            assign lines_n = keys_n_i;
        end
    endgenerate

    // The top cell is always enabled; each cell feeds the one below.
    assign en_chain[NCELLS] = 1'b1;

    generate
        for (genvar c = 0; c < NCELLS; c++) begin : g_cell
            kpe_prio_cell u_cell (
                .en_i      (en_chain[c+1]),
                .lines_n_i (lines_n[c*KPE_LANES +: KPE_LANES]),
                .res_o     (cell_res[c])
            );
            assign en_chain[c] = cell_res[c].eo;
            assign gs_vec[c]   = cell_res[c].gs;
        end
    endgenerate

    logic [KPE_LANE_W-1:0] low_bits;
    logic [SEL_W-1:0]      sel_bits;

    // Disabled cells drive zero, so ORing merges the single active result.
    always_comb begin
        low_bits = '0;
        sel_bits = '0;
        for (int c = 0; c < NCELLS; c++) begin
            low_bits = low_bits | cell_res[c].code;
            if (gs_vec[c]) begin
                sel_bits = sel_bits | SEL_W'(c);
            end
        end
    end

    assign code_o = {sel_bits, low_bits};
    assign any_o  = ~en_chain[0];

    // R8: the enable chain lets at most one cell claim a key.
    always_comb begin
        a_r8_single_group: assert ($onehot0(gs_vec))
            else $error("more than one cell active");
    end

    // R3: the enable leaving the chain agrees with the group selects.
    always_comb begin
        a_r3_chain_agrees: assert (any_o == (|gs_vec))
            else $error("chain end disagrees with group selects");
    end

endmodule

// File: rtl/kpe_keypad_encoder.sv
module kpe_keypad_encoder
    import kpe_pkg::*;
#(
    parameter int NUM_KEYS = 10,
    localparam int CODE_W  = $clog2(NUM_KEYS)
)(
    input  logic [NUM_KEYS-1:0]   digit_keys_n,
    input  logic [KPE_LANES-1:0]  op_keys_n,
    output logic [CODE_W-1:0]     digit_code_o,
    output logic                  digit_valid_o,
    output logic [KPE_LANE_W-1:0] op_code_o,
    output logic                  op_valid_o
);

    kpe_cascade #(
        .NUM_KEYS (NUM_KEYS)
    ) u_digits (
        .keys_n_i (digit_keys_n),
        .code_o   (digit_code_o),
        .any_o    (digit_valid_o)
    );

    kpe_cell_t op_res;
    kpe_op_e   op_sel;

    kpe_prio_cell u_ops (
        .en_i      (1'b1),
        .lines_n_i (op_keys_n),
        .res_o     (op_res)
    );

    assign op_sel     = kpe_op_e'(op_res.code);
    assign op_code_o  = op_sel;
    assign op_valid_o = op_res.gs;

    // R4: an idle digit pad shows code zero.
    always_comb begin
        if (!digit_valid_o) begin
            a_r4_idle_zero: assert (digit_code_o == '0)
                else $error("idle digit code not zero");
        end
    end

    // R1: a valid digit code always names an existing key that is held.
    always_comb begin
        if (digit_valid_o) begin
            a_r1_code_in_range: assert (32'(digit_code_o) < NUM_KEYS)
                else $error("digit code out of range");
        end
    end

    // R6: the operation cell's pass-on enable is high only when idle.
    always_comb begin
        a_r6_op_idle: assert (op_res.eo == (&op_keys_n))
            else $error("operation idle flag wrong");
    end

endmodule

// File: tb/kpe_keypad_encoder_test.sv
module kpe_keypad_encoder_test;

    localparam int NK = 10;

    logic          clk = 1'b0;
    logic [NK-1:0] dk_n;
    logic [3:0]    ok_n;
    logic [3:0]    d_code;
    logic          d_val;
    logic [1:0]    o_code;
    logic          o_val;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;
    bit done     = 0;

    always #4 clk = ~clk;   // 125 MHz

    kpe_keypad_encoder #(.NUM_KEYS(NK)) uut (
        .digit_keys_n  (dk_n),
        .op_keys_n     (ok_n),
        .digit_code_o  (d_code),
        .digit_valid_o (d_val),
        .op_code_o     (o_code),
        .op_valid_o    (o_val)
    );

    function automatic logic [3:0] ref_digit(input logic [NK-1:0] k);
        logic [3:0] r = 4'd0;
        for (int i = 0; i < NK; i++) if (!k[i]) r = 4'(i);
        return r;
    endfunction

    function automatic logic [1:0] ref_op(input logic [3:0] k);
        logic [1:0] r = 2'd0;
        for (int i = 0; i < 4; i++) if (!k[i]) r = 2'(i);
        return r;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Drive on the falling edge, sample one time unit later.
    task automatic apply(input logic [NK-1:0] d, input logic [3:0] o, input string req);
        @(negedge clk);
        dk_n = d;
        ok_n = o;
        #1;
        check(req, "digit_code", int'(d_code), int'(ref_digit(d)));
        check(req, "digit_valid", int'(d_val), int'(~&d));
        check(req, "op_code", int'(o_code), int'(ref_op(o)));
        check(req, "op_valid", int'(o_val), int'(~&o));
    endtask

    initial begin
        dk_n = '1;
        ok_n = '1;
        repeat (2) @(posedge clk);
        // R4 R6: idle state
        apply('1, 4'hF, "R4_R6_idle");
        // R1: every single digit key
        for (int i = 0; i < NK; i++) apply(~(NK'(1) << i), 4'hF, "R1_single");
        // R5: every single operation key
        for (int i = 0; i < 4; i++) apply('1, ~(4'(1) << i), "R5_single_op");
        // R2: multi-key across groups and within the partial top group
        apply(~NK'(10'b0000000011), 4'hF, "R2_same_cell");
        apply(~NK'(10'b0000010001), 4'hF, "R2_two_cells");
        apply(~NK'(10'b1100000000), 4'hF, "R2_top_cell");
        apply(~NK'(10'b0100100001), 4'hF, "R2_three_cells");
        apply('0, 4'hF, "R2_all_pressed");
        // R5: operation priority
        apply('1, 4'b0000, "R5_all_ops");
        apply('1, 4'b1100, "R5_sub_add");
        // R7: pads independent
        apply(~NK'(10'b0000001000), 4'b0110, "R7_both");
        apply('1, 4'b0111, "R7_op_only");
        apply(~NK'(10'b1000000000), 4'hF, "R7_digit_only");
        // R3: random mix
        void'($urandom(32'd2024));
        for (int n = 0; n < 400; n++) begin
            logic [NK-1:0] d;
            logic [3:0]    o;
            d = NK'($urandom);
            o = 4'($urandom);
            if (n % 3 == 0) d = d | NK'($urandom);   // sparser presses
            apply(d, o, "R3_random");
        end
        done = 1;
    end

    initial begin
        while (!done && cycles < 20000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=<%0d", cycles, 20000);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule